// File: doc/BRIEF.md
# Stepping Indirect Memory Access Ports

This block sits between a CPU's byte-wide register bus and a 128 KB video memory. The memory is not mapped into the CPU's address space. Software reaches it through two access channels, A and B. Each channel holds a 17-bit pointer, a stride code and a direction bit. A single set of three pointer registers edits whichever channel a control bit selects.

Reading or writing a channel's data register does three things in turn. It moves one byte to or from memory at that channel's pointer. It then steps the pointer by a signed stride taken from a fixed table. Last, it prefetches the byte at the new pointer, so that the next read returns at once. The table holds powers of two up to 512 and the row-sized steps 40, 80, 160, 320 and 640, so software can walk a row, a column or a sprite stripe without reloading the pointer.

The memory side is a plain synchronous single-port RAM. A read requested in one cycle returns its data in the next cycle. A control bit returns every register of the block to its reset value.

Top module: `vram_dual_port`

## Requirements
- R1: Offsets 0, 1 and 2 access the selected channel's pointer. Offset 0 holds bits 7:0 and offset 1 holds bits 15:8. Offset 2 packs bit 16 in bit 0, the direction bit in bit 3 and the stride code in bits 7:4; its bits 2:1 read as 0. Reading these offsets has no side effect.
- R2: Offset 5 is control. Bit 0 selects the channel shown at offsets 0 to 2 (0 = A, 1 = B) and reads back; all its other bits read as 0.
- R3: Stride codes 0 to 15 give steps of 0, 1, 2, 4, 8, 16, 32, 64, 128, 256, 512, 40, 80, 160, 320 and 640.
- R4: Each read or write of a channel's data register moves that channel's pointer by its stride. The stride is subtracted when the direction bit is 1 and added when it is 0, and the result wraps modulo 2^17.
- R5: A write to offset 3 (channel A) or offset 4 (channel B) writes the byte to memory in the same cycle, at the channel's pointer as it was before the step.
- R6: A data register read returns the memory byte at the channel's current pointer. This holds once 4 quiet cycles have passed since the last access, pointer write or reset.
- R7: Writing any pointer register of the selected channel makes that channel fetch the byte at its new pointer.
- R8: A data write to the address held by the other channel's pointer refreshes the other channel's prefetched byte.
- R9: An access on one channel leaves the other channel's pointer unchanged.
- R10: Writing control with bit 7 set puts both pointers, stride codes and direction bits to 0 and selects channel A. Both channels then prefetch the byte at address 0.
- R11: A memory write and a memory read are never requested in the same cycle; a CPU data write takes the memory ahead of any pending prefetch.
- R12: After reset all pointer and control registers read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; it causes side effects only at data offsets |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| mem_addr | output | 17 | Memory address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 8 | Memory write data |
| mem_re | output | 1 | Memory read request; data is due one cycle later |
| mem_rdata | input | 8 | Memory read data |

## Verification
The bench builds the block with its defaults: a 17-bit pointer, a 4-bit stride code and two channels. With these defaults the wrap at the top of the 128 KB space is reached directly, and all sixteen stride codes can be swept in both directions. The memory behind the block is a sparse model, so addresses near 0x1FFFF cost no storage. Two channels are also enough to place both pointers on one byte and observe the refresh across channels.

// File: rtl/vdp_pkg.sv
package vdp_pkg;
    localparam int ADDR_W  = 17;
    localparam int CODE_W  = 4;
    localparam int DATA_W  = 8;
    localparam int NPORTS  = 2;
    localparam int REG_AW  = 3;
    localparam int IDX_W   = (NPORTS > 1) ? $clog2(NPORTS) : 1;

    localparam logic [REG_AW-1:0] OFF_PTR_LO = 3'd0;
    localparam logic [REG_AW-1:0] OFF_PTR_MD = 3'd1;
    localparam logic [REG_AW-1:0] OFF_PTR_HI = 3'd2;
    localparam logic [REG_AW-1:0] OFF_DATA_A = 3'd3;
    localparam logic [REG_AW-1:0] OFF_DATA_B = 3'd4;
    localparam logic [REG_AW-1:0] OFF_CTRL   = 3'd5;

    typedef logic [ADDR_W-1:0] vaddr_t;

    typedef struct packed {
        vaddr_t              addr;
        logic [CODE_W-1:0]   code;
        logic                decr;
        logic [DATA_W-1:0]   hold;
        logic                pend;
    } chan_t;

    typedef struct packed {
        chan_t [NPORTS-1:0]  ch;
        logic                sel;
        logic                infl_vld;
        logic [IDX_W-1:0]    infl_idx;
    } state_t;

    function automatic state_t rst_state();
        state_t s;
        s = '0;
        for (int i = 0; i < NPORTS; i++) begin
            s.ch[i].pend = 1'b1;
        end
        return s;
    endfunction
endpackage

// File: rtl/vdp_stride_unit.sv
module vdp_stride_unit #(
    parameter int ADDR_W = 17,
    parameter int CODE_W = 4
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [CODE_W-1:0] code,
    input  logic              decr,
    output logic [ADDR_W-1:0] next_addr
);
    localparam logic [CODE_W-1:0] LAST_POW = CODE_W'(10);
    localparam logic [CODE_W-1:0] ONE      = CODE_W'(1);
    localparam logic [CODE_W-1:0] ROW_BASE = CODE_W'(8);

    logic [ADDR_W-1:0] step;

    always_comb begin
        if (code == '0) begin
            step = '0;
        end else if (code <= LAST_POW) begin
            step = ADDR_W'(1) << (code - ONE);
        end else begin
            step = ADDR_W'(5) << (code - ROW_BASE);
        end
        next_addr = decr ? (cur_addr - step) : (cur_addr + step);
    end
endmodule

// File: rtl/vdp_fetch_arb.sv
module vdp_fetch_arb #(
    parameter int NPORTS = 2,
    parameter int IDX_W  = 1
) (
    input  logic [NPORTS-1:0] pend,
    input  logic              blocked,
    output logic              grant_vld,
    output logic [IDX_W-1:0]  grant_idx
);
    always_comb begin
        grant_vld = 1'b0;
        grant_idx = '0;
        for (int i = NPORTS - 1; i >= 0; i--) begin
            if (pend[i] && !blocked) begin
                grant_vld = 1'b1;
                grant_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/vdp_hit_cmp.sv
module vdp_hit_cmp #(
    parameter int NPORTS = 2,
    parameter int ADDR_W = 17
) (
    input  logic [NPORTS-1:0][ADDR_W-1:0] chan_addr,
    input  logic [ADDR_W-1:0]             wr_addr,
    output logic [NPORTS-1:0]             hit
);
    for (genvar g = 0; g < NPORTS; g++) begin : g_cmp
        assign hit[g] = (chan_addr[g] == wr_addr);
    end
endmodule

// File: rtl/vram_dual_port.sv
module vram_dual_port
    import vdp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic [16:0]       mem_addr,
    output logic              mem_we,
    output logic [7:0]        mem_wdata,
    output logic              mem_re,
    input  logic [7:0]        mem_rdata
);
    state_t st_q, st_d;

    logic [NPORTS-1:0][ADDR_W-1:0] chan_addr;
    logic [NPORTS-1:0][ADDR_W-1:0] chan_next;
    logic [NPORTS-1:0][CODE_W-1:0] chan_code;
    logic [NPORTS-1:0]             chan_pend;
    logic [NPORTS-1:0]             wr_hit;
    logic                          grant_vld;
    logic [IDX_W-1:0]              grant_idx;

    logic       is_data, data_wr, data_rd, ptr_wr, ctrl_wr;
    logic       dsel;
    chan_t      cur;

    assign is_data = (reg_addr == OFF_DATA_A) || (reg_addr == OFF_DATA_B);
    assign dsel    = (reg_addr == OFF_DATA_B);
    assign data_wr = reg_wr && is_data;
    assign data_rd = reg_rd && !reg_wr && is_data;
    assign ptr_wr  = reg_wr && (reg_addr <= OFF_PTR_HI);
    assign ctrl_wr = reg_wr && (reg_addr == OFF_CTRL);

    for (genvar g = 0; g < NPORTS; g++) begin : g_chan
        assign chan_addr[g] = st_q.ch[g].addr;
        assign chan_code[g] = st_q.ch[g].code;
        assign chan_pend[g] = st_q.ch[g].pend;
        vdp_stride_unit #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) step_i (
            .cur_addr  (st_q.ch[g].addr),
            .code      (st_q.ch[g].code),
            .decr      (st_q.ch[g].decr),
            .next_addr (chan_next[g])
        );
    end

    vdp_fetch_arb #(.NPORTS(NPORTS), .IDX_W(IDX_W)) arb_i (
        .pend      (chan_pend),
        .blocked   (data_wr),
        .grant_vld (grant_vld),
        .grant_idx (grant_idx)
    );

    vdp_hit_cmp #(.NPORTS(NPORTS), .ADDR_W(ADDR_W)) hit_i (
        .chan_addr (chan_addr),
        .wr_addr   (chan_addr[dsel]),
        .hit       (wr_hit)
    );

    // next-state and memory request
    always_comb begin
        st_d      = st_q;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        mem_addr  = chan_addr[dsel];
        mem_wdata = reg_wdata;

        // returning prefetch data, dropped if the channel was re-armed since
        st_d.infl_vld = 1'b0;
        if (st_q.infl_vld && !st_q.ch[st_q.infl_idx].pend) begin
            st_d.ch[st_q.infl_idx].hold = mem_rdata;
        end

        // issue one pending prefetch when the CPU is not writing
        if (grant_vld) begin
            mem_re                   = 1'b1;
            mem_addr                 = chan_addr[grant_idx];
            st_d.infl_vld            = 1'b1;
            st_d.infl_idx            = grant_idx;
            st_d.ch[grant_idx].pend  = 1'b0;
        end

        if (data_wr) begin
            mem_we = 1'b1;
            for (int i = 0; i < NPORTS; i++) begin
                if (wr_hit[i]) begin
                    st_d.ch[i].pend = 1'b1;
                end
            end
            st_d.ch[dsel].addr = chan_next[dsel];
            st_d.ch[dsel].pend = 1'b1;
        end

        if (data_rd) begin
            st_d.ch[dsel].addr = chan_next[dsel];
            st_d.ch[dsel].pend = 1'b1;
        end

        if (ptr_wr) begin
            case (reg_addr)
                OFF_PTR_LO: st_d.ch[st_q.sel].addr[7:0]  = reg_wdata;
                OFF_PTR_MD: st_d.ch[st_q.sel].addr[15:8] = reg_wdata;
                default: begin
                    st_d.ch[st_q.sel].addr[ADDR_W-1] = reg_wdata[0];
                    st_d.ch[st_q.sel].decr           = reg_wdata[3];
                    st_d.ch[st_q.sel].code           = reg_wdata[7:4];
                end
            endcase
            st_d.ch[st_q.sel].pend = 1'b1;
        end

        if (ctrl_wr) begin
            if (reg_wdata[7]) begin
                st_d = rst_state();
            end else begin
                st_d.sel = reg_wdata[0];
            end
        end
    end

    // register read mux
    always_comb begin
        cur = st_q.ch[st_q.sel];
        case (reg_addr)
            OFF_PTR_LO: reg_rdata = cur.addr[7:0];
            OFF_PTR_MD: reg_rdata = cur.addr[15:8];
            OFF_PTR_HI: reg_rdata = {cur.code, cur.decr, 2'b00, cur.addr[ADDR_W-1]};
            OFF_DATA_A: reg_rdata = st_q.ch[0].hold;
            OFF_DATA_B: reg_rdata = st_q.ch[1].hold;
            OFF_CTRL:   reg_rdata = {7'b0, st_q.sel};
            default:    reg_rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= rst_state();
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/vdp_checks.sv
module vdp_checks
    import vdp_pkg::*;
(
    input logic                          clk,
    input logic                          rst_n,
    input logic [2:0]                    reg_addr,
    input logic                          reg_wr,
    input logic                          reg_rd,
    input logic [7:0]                    reg_wdata,
    input logic                          mem_we,
    input logic                          mem_re,
    input logic [NPORTS-1:0][ADDR_W-1:0] chan_addr,
    input logic [NPORTS-1:0][CODE_W-1:0] chan_code,
    input logic [7:0]                    reg_rdata
);
    logic rd_a;
    assign rd_a = reg_rd && !reg_wr && (reg_addr == OFF_DATA_A);

    // R11
    mem_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    // R5
    wr_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (reg_wr && (reg_addr == OFF_DATA_A || reg_addr == OFF_DATA_B)));

    // R9
    other_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_a |=> $stable(chan_addr[1]));

    // R4
    step_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a && chan_code[0] != '0) |=> (chan_addr[0] != $past(chan_addr[0])));

    // R3
    zero_stride_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a && chan_code[0] == '0) |=> $stable(chan_addr[0]));

    // R10
    soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFF_CTRL && reg_wdata[7])
        |=> (chan_addr[0] == '0 && chan_addr[1] == '0 && reg_rdata == 8'h00));
endmodule

bind vram_dual_port vdp_checks chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_wdata (reg_wdata),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .chan_addr (chan_addr),
    .chan_code (chan_code),
    .reg_rdata (reg_rdata)
);

// File: tb/vram_dual_port_tb.sv
module vram_dual_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [16:0] mem_addr;
    logic        mem_we;
    logic [7:0]  mem_wdata;
    logic        mem_re;
    logic [7:0]  mem_rdata = '0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    vram_dual_port dut_i (.*);

    // sparse memory behind the block
    logic [7:0] ram [int];
    logic [7:0] ref_mem [int];

    function automatic logic [7:0] fill(int a);
        return 8'((a * 7 + 3) ^ (a >> 8));
    endfunction

    function automatic logic [7:0] ram_get(int a);
        return ram.exists(a) ? ram[a] : fill(a);
    endfunction

    function automatic logic [7:0] ref_get(int a);
        return ref_mem.exists(a) ? ref_mem[a] : fill(a);
    endfunction

    always @(posedge clk) begin
        if (mem_re) mem_rdata <= ram_get(int'(mem_addr));
        if (mem_we) ram[int'(mem_addr)] = mem_wdata;
    end

    // reference model state
    int m_ad [2];
    int m_code [2];
    bit m_dec [2];
    int m_sel;

    function automatic int stride_of(int c);
        case (c)
            0: return 0;    1: return 1;    2: return 2;    3: return 4;
            4: return 8;    5: return 16;   6: return 32;   7: return 64;
            8: return 128;  9: return 256;  10: return 512; 11: return 40;
            12: return 80;  13: return 160; 14: return 320; default: return 640;
        endcase
    endfunction

    function automatic void model_step(int p);
        int s;
        s = stride_of(m_code[p]);
        m_ad[p] = (m_dec[p] ? m_ad[p] - s : m_ad[p] + s) & 'h1FFFF;
    endfunction

    function automatic void model_reset();
        for (int p = 0; p < 2; p++) begin
            m_ad[p] = 0; m_code[p] = 0; m_dec[p] = 0;
        end
        m_sel = 0;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // compared on every clock: memory never read and written together
    always @(negedge clk) begin
        #1;
        if (rst_n && mem_we && mem_re) begin
            errors++;
            $display("FAIL R11 actual=we+re expected=one");
        end
    end

    task automatic drive(logic [2:0] a, bit w, bit r, logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wr = w; reg_rd = r; reg_wdata = d;
        #1;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) drive(3'd0, 0, 0, 8'h00);
    endtask

    task automatic wreg(logic [2:0] a, logic [7:0] d);
        int p;
        drive(a, 1, 0, d);
        if (a == 3'd3 || a == 3'd4) begin
            p = (a == 3'd4) ? 1 : 0;
            check("R5 we", int'(mem_we), 1);
            check("R5 addr", int'(mem_addr), m_ad[p]);
            check("R5 data", int'(mem_wdata), int'(d));
            ref_mem[m_ad[p]] = d;
            model_step(p);
        end else if (a == 3'd0) begin
            m_ad[m_sel] = (m_ad[m_sel] & 'h1FF00) | int'(d);
        end else if (a == 3'd1) begin
            m_ad[m_sel] = (m_ad[m_sel] & 'h100FF) | (int'(d) << 8);
        end else if (a == 3'd2) begin
            m_ad[m_sel] = (m_ad[m_sel] & 'h0FFFF) | (int'(d[0]) << 16);
            m_dec[m_sel] = d[3];
            m_code[m_sel] = int'(d[7:4]);
        end else if (a == 3'd5) begin
            if (d[7]) model_reset();
            else m_sel = int'(d[0]);
        end
        idle(4);
    endtask

    task automatic rdata(int p, string req);
        drive(p ? 3'd4 : 3'd3, 0, 1, 8'h00);
        check(req, int'(reg_rdata), int'(ref_get(m_ad[p])));
        model_step(p);
        idle(4);
    endtask

    task automatic rptr(string req);
        int v;
        drive(3'd0, 0, 0, 8'h00); v = int'(reg_rdata);
        drive(3'd1, 0, 0, 8'h00); v |= int'(reg_rdata) << 8;
        drive(3'd2, 0, 0, 8'h00);
        check({req, " hi-flags"}, int'(reg_rdata[7:1]),
              (m_code[m_sel] << 3) | (int'(m_dec[m_sel]) << 2));
        v |= int'(reg_rdata[0]) << 16;
        check({req, " ptr"}, v, m_ad[m_sel]);
    endtask

    task automatic setptr(int a, int c, bit dn);
        wreg(3'd2, {4'(c), dn, 2'b00, 1'(a >> 16)});
        wreg(3'd1, 8'(a >> 8));
        wreg(3'd0, 8'(a));
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        idle(4);

        // R12 reset state, R2 control reads back 0
        rptr("R12 R1");
        drive(3'd5, 0, 0, 8'h00);
        check("R12 R2 ctrl", int'(reg_rdata), 0);

        // R6 prefetch after reset; R3 code 0 keeps the pointer
        rdata(0, "R6 reset fetch");
        rptr("R3 code0");

        // R4 wrap at top of space with code 1
        setptr('h1FFFE, 1, 0);
        rptr("R1 R7 load");
        rdata(0, "R7 R6 fetch 1FFFE");
        rdata(0, "R4 R6 1FFFF");
        rdata(0, "R4 wrap 0");
        rptr("R4 after wrap");

        // R4 decrement by 40 below zero
        setptr(10, 11, 1);
        rdata(0, "R6 dec");
        rptr("R4 dec wrap");

        // R3 sweep of every code in both directions
        for (int c = 0; c < 16; c++) begin
            setptr('h800, c, 0);
            wreg(3'd3, 8'(c + 1));
            rptr("R3 inc sweep");
            setptr('h800, c, 1);
            rdata(0, "R3 R6 dec sweep");
            rptr("R3 dec sweep");
        end

        // R2 select channel B; R9 channel A untouched
        setptr('h1234, 2, 0);
        wreg(3'd5, 8'h01);
        drive(3'd5, 0, 0, 8'h00);
        check("R2 ctrl", int'(reg_rdata), 1);
        setptr('h300, 2, 0);
        wreg(3'd4, 8'h11);
        wreg(3'd4, 8'h22);
        rptr("R4 chanB");
        wreg(3'd5, 8'h00);
        rptr("R9 chanA kept");
        wreg(3'd5, 8'h01);
        setptr('h300, 3, 1);
        rdata(1, "R6 chanB readback");

        // R8 write through A to B's address
        setptr('h5000, 0, 0);
        wreg(3'd5, 8'h00);
        setptr('h5000, 0, 0);
        wreg(3'd3, 8'hA5);
        rdata(1, "R8 B refreshed");
        rdata(0, "R6 A own write");
        setptr('h6000, 1, 0);
        wreg(3'd5, 8'h01);
        setptr('h6001, 0, 0);
        wreg(3'd5, 8'h00);
        wreg(3'd3, 8'h3C);
        wreg(3'd3, 8'hC3);
        rdata(1, "R8 B second");

        // R10 soft reset
        wreg(3'd5, 8'h81);
        drive(3'd5, 0, 0, 8'h00);
        check("R10 ctrl", int'(reg_rdata), 0);
        rptr("R10 chanA");
        wreg(3'd5, 8'h01);
        rptr("R10 chanB");
        rdata(1, "R10 B fetch 0");
        wreg(3'd5, 8'h00);
        rdata(0, "R10 A fetch 0");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule